// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a virtual address into a real address by walking a multi-level radix tree held in memory. Each request supplies the address, the root directory base, the number of index bits used at the root and the starting page-size exponent. Optionally the walk starts one step earlier: a per-process table is indexed by a process identifier, and the entry found there supplies the root base, root index width and page-size exponent. Memory is reached through a single 64-bit read port with a request strobe and a data-valid return. Only one read is in flight at any time. The walk ends either with a leaf result or with a fault cause.

At every level the index width comes from the directory entry that was just read. The page-size exponent drops by that width after each fetch. When the walk reaches a leaf, the exponent that remains sets the page size. The real address takes the leaf's page-number field above that size and the input address bits below it.

The controller has six states. In IDLE it accepts a request: it goes to TBL_RD when the table lookup is requested and in range, to DONE on an out-of-range process id, and otherwise to LVL_RD. TBL_RD issues the table read and always moves to TBL_WT. TBL_WT waits for data, loads the root fields and moves to LVL_RD. LVL_RD either faults to DONE on a bad configuration, or issues the entry read and moves to LVL_WT. LVL_WT waits for data and then goes to DONE on an invalid entry or a leaf, or back to LVL_RD on a directory. DONE always returns to IDLE.

Top module: `radix_walk`

## Requirements
- R1: If the index width at the root, or one taken from a directory entry, is below 5, the walk ends with fault_cause 2 (bad configuration) and issues no read for that level.
- R2: The entry address at a level is base + 8 × ((address >> (psize − width)) & (2^width − 1)), where psize is the current page-size exponent and width the current index width.
- R3: A fetched entry whose bit 63 (valid) is 0 ends the walk with fault high and fault_cause 1 (no entry).
- R4: After each valid fetch the page-size exponent is reduced by that level's index width. On a leaf, page_exp reports the remaining value.
- R5: A valid entry with bit 62 (leaf) clear is a directory. Its bits [55:8] with the low 8 bits zero form the next base, and its bits [4:0] give the next index width.
- R6: On a leaf, fault is 0 and fault_cause is 0. real_addr is the entry's bits [55:12] with the low page_exp bits cleared, ORed with the low page_exp bits of the input address. leaf_entry and leaf_addr report the leaf and the address it was read from.
- R7: With table lookup selected, the table entry is read at table base + 16 × pid. Its bits [61:56] give the start exponent, bits [55:8] the root base and bits [4:0] the root width. If 16 × pid is at least 2^(size field + 12), the walk ends with fault_cause 1 and no read.
- R8: The walk ends with fault_cause 2 before any read that would need an index width larger than the current exponent, or a level beyond MAX_LEVELS.
- R9: rd_req is high for exactly one cycle per read. No further read is issued until rd_valid has returned the data.
- R10: done is a one-cycle pulse, after which busy is low. The result outputs hold their values until the next request is accepted.
- R11: A request presented while busy is high is ignored. It causes no read and no later walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken only when not busy) |
| req_addr | input | 64 | Address to translate |
| req_use_tbl | input | 1 | Look up the process table before the walk |
| req_pid | input | PID_W | Process identifier for the table lookup |
| tbl_base | input | 64 | Process table base address |
| tbl_size_log | input | 5 | Table size field: size is 2^(field+12) bytes |
| root_base | input | 64 | Root directory base (no table lookup) |
| root_nls | input | 5 | Root index width (no table lookup) |
| root_psize | input | 6 | Start page-size exponent (no table lookup) |
| busy | output | 1 | Walk in progress, through the done cycle |
| rd_req | output | 1 | Memory read strobe |
| rd_addr | output | 64 | Memory read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 64 | Read data |
| done | output | 1 | Walk finished (one cycle) |
| fault | output | 1 | Walk ended in a fault |
| fault_cause | output | 2 | 0 none, 1 no entry, 2 bad configuration |
| real_addr | output | 64 | Translated real address |
| page_exp | output | 7 | Final page-size exponent |
| leaf_entry | output | 64 | Leaf entry contents |
| leaf_addr | output | 64 | Address of the leaf entry |

## Verification
On every cycle the assertions check the following. Reads are single-cycle strobes with 8-byte alignment, and one walk never issues more reads than the level bound allows. done is a pulse followed by idle, and fault agrees with a nonzero cause. A root width below 5 faults two cycles after acceptance, and an out-of-range process id faults one cycle after. Only the bench's scenarios can show the rest: that the address sequence matches the index arithmetic as widths change from level to level, the leaf merge at different page sizes, the table lookup and its range boundary, the depth and width limits, and that a request made while busy leaves no trace.

// File: rtl/radix_walk_pkg.sv
package radix_walk_pkg;

    localparam int DW      = 64;
    localparam int NLS_W   = 5;
    localparam int MIN_NLS = 5;

    localparam int VALID_BIT = 63;
    localparam int LEAF_BIT  = 62;

    localparam logic [DW-1:0] NEXT_BASE_MASK = 64'h00FF_FFFF_FFFF_FF00;
    localparam logic [DW-1:0] PAGE_NUM_MASK  = 64'h00FF_FFFF_FFFF_F000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TBL_RD,
        ST_TBL_WT,
        ST_LVL_RD,
        ST_LVL_WT,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_NOENT  = 2'd1,
        CAUSE_BADCFG = 2'd2
    } walk_cause_e;

endpackage

// File: rtl/radix_walk_index.sv
module radix_walk_index
    import radix_walk_pkg::*;
#(
    parameter int PS_W = 7
) (
    input  logic [DW-1:0]    vaddr,
    input  logic [DW-1:0]    base,
    input  logic [NLS_W-1:0] nls,
    input  logic [PS_W-1:0]  psize,
    output logic [DW-1:0]    ent_addr
);

    logic [PS_W-1:0] shamt;
    logic [DW-1:0]   sel_mask;
    logic [DW-1:0]   slot;

    always_comb begin
        shamt    = psize - PS_W'(nls);
        sel_mask = (DW'(1) << nls) - DW'(1);
        slot     = (vaddr >> shamt) & sel_mask;
        ent_addr = base + (slot << 3);
    end

endmodule

// File: rtl/radix_walk_leaf.sv
module radix_walk_leaf
    import radix_walk_pkg::*;
#(
    parameter int PS_W = 7
) (
    input  logic [DW-1:0]   vaddr,
    input  logic [DW-1:0]   entry,
    input  logic [PS_W-1:0] psize,
    output logic [DW-1:0]   raddr
);

    logic [DW-1:0] off_mask;

    always_comb begin
        off_mask = (DW'(1) << psize) - DW'(1);
        raddr    = (entry & PAGE_NUM_MASK & ~off_mask) | (vaddr & off_mask);
    end

endmodule

// File: rtl/radix_walk.sv
module radix_walk
    import radix_walk_pkg::*;
#(
    parameter int PID_W      = 16,
    parameter int MAX_LEVELS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [63:0]      req_addr,
    input  logic             req_use_tbl,
    input  logic [PID_W-1:0] req_pid,
    input  logic [63:0]      tbl_base,
    input  logic [4:0]       tbl_size_log,
    input  logic [63:0]      root_base,
    input  logic [4:0]       root_nls,
    input  logic [5:0]       root_psize,
    output logic             busy,
    output logic             rd_req,
    output logic [63:0]      rd_addr,
    input  logic             rd_valid,
    input  logic [63:0]      rd_data,
    output logic             done,
    output logic             fault,
    output logic [1:0]       fault_cause,
    output logic [63:0]      real_addr,
    output logic [6:0]       page_exp,
    output logic [63:0]      leaf_entry,
    output logic [63:0]      leaf_addr
);

    localparam int PS_W  = 7;
    localparam int LVL_W = $clog2(MAX_LEVELS + 1);

    walk_state_e      state;
    walk_cause_e      cause_q;
    logic [DW-1:0]    va_q, base_q, tbase_q, ent_addr_q;
    logic [PID_W-1:0] pid_q;
    logic [NLS_W-1:0] nls_q;
    logic [PS_W-1:0]  ps_q;
    logic [LVL_W-1:0] lvl_q;
    logic             fault_q;
    logic [DW-1:0]    ra_q, leaf_q, leaf_addr_q;
    logic [PS_W-1:0]  pexp_q;

    logic [DW-1:0]    lvl_addr, tbl_addr, leaf_ra, tbl_limit;
    logic [PS_W-1:0]  ps_after;
    logic             tbl_over, lvl_bad;

    assign tbl_limit = DW'(1) << (6'(tbl_size_log) + 6'd8);
    assign tbl_over  = DW'(req_pid) >= tbl_limit;
    assign tbl_addr  = tbase_q + (DW'(pid_q) << 4);
    assign ps_after  = ps_q - PS_W'(nls_q);
    assign lvl_bad   = (nls_q < NLS_W'(MIN_NLS)) ||
                       (PS_W'(nls_q) > ps_q) ||
                       (lvl_q == LVL_W'(MAX_LEVELS));

    radix_walk_index #(.PS_W(PS_W)) u_index (
        .vaddr    (va_q),
        .base     (base_q),
        .nls      (nls_q),
        .psize    (ps_q),
        .ent_addr (lvl_addr)
    );

    radix_walk_leaf #(.PS_W(PS_W)) u_leaf (
        .vaddr (va_q),
        .entry (rd_data),
        .psize (ps_after),
        .raddr (leaf_ra)
    );

    // State register and walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cause_q     <= CAUSE_NONE;
            fault_q     <= 1'b0;
            va_q        <= '0;
            base_q      <= '0;
            tbase_q     <= '0;
            ent_addr_q  <= '0;
            pid_q       <= '0;
            nls_q       <= '0;
            ps_q        <= '0;
            lvl_q       <= '0;
            ra_q        <= '0;
            leaf_q      <= '0;
            leaf_addr_q <= '0;
            pexp_q      <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q        <= req_addr;
                        pid_q       <= req_pid;
                        tbase_q     <= tbl_base;
                        base_q      <= root_base;
                        nls_q       <= root_nls;
                        ps_q        <= PS_W'(root_psize);
                        lvl_q       <= '0;
                        fault_q     <= 1'b0;
                        cause_q     <= CAUSE_NONE;
                        ra_q        <= '0;
                        leaf_q      <= '0;
                        leaf_addr_q <= '0;
                        pexp_q      <= '0;
                        if (req_use_tbl && tbl_over) begin
                            fault_q <= 1'b1;
                            cause_q <= CAUSE_NOENT;
                            state   <= ST_DONE;
                        end else if (req_use_tbl) begin
                            state <= ST_TBL_RD;
                        end else begin
                            state <= ST_LVL_RD;
                        end
                    end
                end
                ST_TBL_RD: state <= ST_TBL_WT;
                ST_TBL_WT: begin
                    if (rd_valid) begin
                        base_q <= rd_data & NEXT_BASE_MASK;
                        nls_q  <= rd_data[NLS_W-1:0];
                        ps_q   <= PS_W'(rd_data[61:56]);
                        state  <= ST_LVL_RD;
                    end
                end
                ST_LVL_RD: begin
                    if (lvl_bad) begin
                        fault_q <= 1'b1;
                        cause_q <= CAUSE_BADCFG;
                        state   <= ST_DONE;
                    end else begin
                        ent_addr_q <= lvl_addr;
                        lvl_q      <= lvl_q + LVL_W'(1);
                        state      <= ST_LVL_WT;
                    end
                end
                ST_LVL_WT: begin
                    if (rd_valid) begin
                        if (!rd_data[VALID_BIT]) begin
                            fault_q <= 1'b1;
                            cause_q <= CAUSE_NOENT;
                            state   <= ST_DONE;
                        end else if (rd_data[LEAF_BIT]) begin
                            ps_q        <= ps_after;
                            pexp_q      <= ps_after;
                            ra_q        <= leaf_ra;
                            leaf_q      <= rd_data;
                            leaf_addr_q <= ent_addr_q;
                            state       <= ST_DONE;
                        end else begin
                            base_q <= rd_data & NEXT_BASE_MASK;
                            nls_q  <= rd_data[NLS_W-1:0];
                            ps_q   <= ps_after;
                            state  <= ST_LVL_RD;
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy        = (state != ST_IDLE);
        done        = (state == ST_DONE);
        rd_req      = 1'b0;
        rd_addr     = '0;
        unique case (state)
            ST_TBL_RD: begin
                rd_req  = 1'b1;
                rd_addr = tbl_addr;
            end
            ST_LVL_RD: begin
                rd_req  = !lvl_bad;
                rd_addr = lvl_bad ? '0 : lvl_addr;
            end
            default: begin
                rd_req  = 1'b0;
                rd_addr = '0;
            end
        endcase
        fault       = fault_q;
        fault_cause = cause_q;
        real_addr   = ra_q;
        page_exp    = pexp_q;
        leaf_entry  = leaf_q;
        leaf_addr   = leaf_addr_q;
    end

endmodule

// File: rtl/radix_walk_chk.sv
module radix_walk_chk #(
    parameter int PID_W      = 16,
    parameter int MAX_LEVELS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             busy,
    input logic             req_use_tbl,
    input logic [PID_W-1:0] req_pid,
    input logic [4:0]       tbl_size_log,
    input logic [4:0]       root_nls,
    input logic             rd_req,
    input logic [2:0]       rd_addr_lo,
    input logic             done,
    input logic             fault,
    input logic [1:0]       fault_cause
);

    localparam int CW = $clog2(MAX_LEVELS + 2) + 1;

    logic [CW-1:0] reads;

    always_ff @(posedge clk) begin
        if (!rst_n)      reads <= '0;
        else if (done)   reads <= '0;
        else if (rd_req) reads <= reads + CW'(1);
    end

    // R9: a read strobe lasts one cycle
    a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R2: entry addresses are 8-byte aligned
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr_lo == 3'd0));

    // R8: table read plus at most MAX_LEVELS level reads per walk
    a_r8_read_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (reads <= CW'(MAX_LEVELS)));

    // R10: done is a pulse followed by idle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R6: fault flag agrees with cause
    a_r6_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fault == (fault_cause != 2'd0)));

    // R1: narrow root index faults two cycles after acceptance
    a_r1_root_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_use_tbl && (root_nls < 5'd5))
        |-> ##2 (done && fault_cause == 2'd2));

    // R7: out-of-range process id faults without a read
    a_r7_tbl_range: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_use_tbl &&
         (64'(req_pid) >= (64'd1 << (6'(tbl_size_log) + 6'd8))))
        |=> (done && fault_cause == 2'd1 && !rd_req));

endmodule

bind radix_walk radix_walk_chk #(.PID_W(PID_W), .MAX_LEVELS(MAX_LEVELS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .busy         (busy),
    .req_use_tbl  (req_use_tbl),
    .req_pid      (req_pid),
    .tbl_size_log (tbl_size_log),
    .root_nls     (root_nls),
    .rd_req       (rd_req),
    .rd_addr_lo   (rd_addr[2:0]),
    .done         (done),
    .fault        (fault),
    .fault_cause  (fault_cause)
);

// File: tb/test_radix_walk.sv
module test_radix_walk;

    localparam int CLK_PERIOD = 10;
    localparam int PID_W      = 16;
    localparam int MAXL       = 4;
    localparam logic [63:0] NB_MASK = 64'h00FF_FFFF_FFFF_FF00;
    localparam logic [63:0] PN_MASK = 64'h00FF_FFFF_FFFF_F000;

    typedef struct packed {
        logic        flt;
        logic [1:0]  cause;
        logic [63:0] ra;
        logic [6:0]  pexp;
        logic [63:0] ent;
        logic [63:0] eaddr;
    } res_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [63:0]      req_addr = '0;
    logic             req_use_tbl = 1'b0;
    logic [PID_W-1:0] req_pid = '0;
    logic [63:0]      tbl_base = '0;
    logic [4:0]       tbl_size_log = '0;
    logic [63:0]      root_base = '0;
    logic [4:0]       root_nls = '0;
    logic [5:0]       root_psize = '0;
    logic             busy, rd_req, done, fault;
    logic [63:0]      rd_addr, real_addr, leaf_entry, leaf_addr;
    logic             rd_valid = 1'b0;
    logic [63:0]      rd_data = '0;
    logic [1:0]       fault_cause;
    logic [6:0]       page_exp;

    logic [63:0] mem [logic [63:0]];
    logic [63:0] exp_rd_q [$];
    int          lat = 1;
    int          nchk = 0;
    int          nerr = 0;

    radix_walk #(.PID_W(PID_W), .MAX_LEVELS(MAXL)) i_radix_walk (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_use_tbl(req_use_tbl), .req_pid(req_pid), .tbl_base(tbl_base),
        .tbl_size_log(tbl_size_log), .root_base(root_base), .root_nls(root_nls),
        .root_psize(root_psize), .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .fault(fault),
        .fault_cause(fault_cause), .real_addr(real_addr), .page_exp(page_exp),
        .leaf_entry(leaf_entry), .leaf_addr(leaf_addr)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [63:0] rdmem(logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    function automatic logic [63:0] ea(logic [63:0] base, logic [63:0] va, int ps, int nls);
        return base + (((va >> (ps - nls)) & ((64'd1 << nls) - 64'd1)) << 3);
    endfunction

    function automatic logic [63:0] mkdir(logic [63:0] nb, int nls);
        return 64'h8000_0000_0000_0000 | (nb & NB_MASK) | 64'(nls);
    endfunction

    function automatic logic [63:0] mkleaf(logic [63:0] pa);
        return 64'hC000_0000_0000_0000 | pa;
    endfunction

    function automatic res_t model(logic ut, logic [PID_W-1:0] pid, logic [63:0] va,
                                   logic [63:0] tb, logic [4:0] tsz, logic [63:0] rb,
                                   logic [4:0] rn, logic [5:0] rp);
        res_t r;
        logic [63:0] base, e, a, m;
        int nls, ps;
        r = '0;
        base = rb;
        nls = int'(rn);
        ps = int'(rp);
        if (ut) begin
            if (64'(pid) >= (64'd1 << (int'(tsz) + 8))) begin
                r.flt = 1'b1; r.cause = 2'd1; return r;
            end
            a = tb + 64'(pid) * 64'd16;
            exp_rd_q.push_back(a);
            e = rdmem(a);
            base = e & NB_MASK;
            nls = int'(e[4:0]);
            ps = int'(e[61:56]);
        end
        for (int lvl = 0; lvl <= MAXL; lvl++) begin
            if (nls < 5 || nls > ps || lvl == MAXL) begin
                r.flt = 1'b1; r.cause = 2'd2; return r;
            end
            a = ea(base, va, ps, nls);
            exp_rd_q.push_back(a);
            e = rdmem(a);
            if (!e[63]) begin
                r.flt = 1'b1; r.cause = 2'd1; return r;
            end
            ps = ps - nls;
            if (e[62]) begin
                m = (64'd1 << ps) - 64'd1;
                r.ra = (e & PN_MASK & ~m) | (va & m);
                r.pexp = 7'(ps);
                r.ent = e;
                r.eaddr = a;
                return r;
            end
            base = e & NB_MASK;
            nls = int'(e[4:0]);
        end
        return r;
    endfunction

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Memory responder: data returns 1+lat cycles after the strobe
    initial begin
        forever begin
            @(negedge clk);
            rd_valid = 1'b0;
            if (rd_req === 1'b1) begin
                logic [63:0] a;
                a = rd_addr;
                repeat (1 + lat) @(negedge clk);
                rd_valid = 1'b1;
                rd_data = rdmem(a);
            end
        end
    end

    // Per-clock comparison of every read against the model's address list (R2, R9)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rd_req === 1'b1) begin
                if (exp_rd_q.size() == 0) begin
                    chk("R11 unexpected read address", rd_addr, 64'd0 - 64'd1);
                end else begin
                    logic [63:0] x;
                    x = exp_rd_q.pop_front();
                    chk("R2 entry address", rd_addr, x);
                end
            end
        end
    end

    task automatic run(string rq, logic ut, logic [PID_W-1:0] pid, logic [63:0] va,
                       logic [63:0] tb, logic [4:0] tsz, logic [63:0] rb, logic [4:0] rn,
                       logic [5:0] rp, int latency, bit poke);
        res_t e;
        int n;
        lat = latency;
        e = model(ut, pid, va, tb, tsz, rb, rn, rp);
        @(negedge clk);
        req_use_tbl = ut; req_pid = pid; req_addr = va; tbl_base = tb;
        tbl_size_log = tsz; root_base = rb; root_nls = rn; root_psize = rp;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (done !== 1'b1 && n < 300) begin
            @(negedge clk);
            n++;
            if (poke && n == 2) begin
                req_valid = 1'b1; req_use_tbl = 1'b0; req_addr = ~va;
                root_nls = 5'd4;
            end else begin
                req_valid = 1'b0;
            end
        end
        req_valid = 1'b0;
        chk({rq, " done seen"}, 64'(done), 64'd1);
        chk({rq, " fault"}, 64'(fault), 64'(e.flt));
        chk({rq, " fault_cause"}, 64'(fault_cause), 64'(e.cause));
        chk({rq, " real_addr"}, real_addr, e.ra);
        chk({rq, " page_exp"}, 64'(page_exp), 64'(e.pexp));
        chk({rq, " leaf_entry"}, leaf_entry, e.ent);
        chk({rq, " leaf_addr"}, leaf_addr, e.eaddr);
        chk({rq, " R9 all reads issued"}, 64'(exp_rd_q.size()), 64'd0);
        @(negedge clk);
        chk({rq, " R10 done pulse ends"}, 64'(done), 64'd0);
        chk({rq, " R10 idle after done"}, 64'(busy), 64'd0);
        chk({rq, " R10 result held"}, real_addr, e.ra);
        if (poke) begin
            @(negedge clk);
            chk("R11 no walk from ignored request", 64'(busy), 64'd0);
            chk("R11 no read from ignored request", 64'(rd_req), 64'd0);
        end
        exp_rd_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [63:0] va_a, va_b, va_c, va_g, b, tb;
        va_a = 64'h0000_0012_3456_7ABC;
        va_b = 64'h0000_0000_0015_4321;
        va_c = 64'h0000_0000_0A5A_5123;
        va_g = 64'h0ABC_DEF0_1234_5678;
        tb   = 64'h0010_0000;

        // three-level tree, start exponent 39
        mem[ea(64'h1_0000, va_a, 39, 9)] = mkdir(64'h2_0000, 9);
        mem[ea(64'h2_0000, va_a, 30, 9)] = mkdir(64'h3_0000, 9);
        mem[ea(64'h3_0000, va_a, 21, 9)] = mkleaf(64'hABCD_E000);
        // large page at level one; low page-number bits must be cleared
        mem[ea(64'h4_0000, va_b, 30, 9)] = 64'hC000_0000_7777_7000;
        // missing second level
        mem[ea(64'h5_0000, va_c, 30, 9)] = mkdir(64'h6_0000, 9);
        // directory with too narrow a width
        mem[ea(64'h7_0000, va_c, 30, 9)] = mkdir(64'h7_8000, 3);
        // chain deeper than the level limit
        b = 64'h8_0000;
        for (int k = 0; k < MAXL; k++) begin
            mem[ea(b, va_g, 60 - 5 * k, 5)] = mkdir(b + 64'h1000, 5);
            b = b + 64'h1000;
        end
        // process table entries
        mem[tb + 64'd48]       = (64'd30 << 56) | 64'h4_0000 | 64'd9;
        mem[tb + 64'd255 * 16] = (64'd30 << 56) | 64'h4_0000 | 64'd9;

        repeat (3) @(negedge clk);
        chk("R10 reset busy", 64'(busy), 64'd0);
        chk("R10 reset done", 64'(done), 64'd0);
        chk("R9 reset rd_req", 64'(rd_req), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run("R4 R5 three-level walk", 1'b0, '0, va_a, '0, '0, 64'h1_0000, 5'd9, 6'd39, 0, 1'b0);
        run("R6 large page leaf", 1'b0, '0, va_b, '0, '0, 64'h4_0000, 5'd9, 6'd30, 1, 1'b0);
        run("R3 invalid entry", 1'b0, '0, va_c, '0, '0, 64'h5_0000, 5'd9, 6'd30, 2, 1'b0);
        run("R1 narrow root", 1'b0, '0, va_c, '0, '0, 64'h5_0000, 5'd4, 6'd30, 1, 1'b0);
        run("R1 narrow directory", 1'b0, '0, va_c, '0, '0, 64'h7_0000, 5'd9, 6'd30, 1, 1'b0);
        run("R8 width above exponent", 1'b0, '0, va_c, '0, '0, 64'h5_0000, 5'd13, 6'd12, 1, 1'b0);
        run("R8 level limit", 1'b0, '0, va_g, '0, '0, 64'h8_0000, 5'd5, 6'd60, 0, 1'b0);
        run("R7 table lookup", 1'b1, 16'd3, va_b, tb, 5'd0, '0, '0, '0, 1, 1'b0);
        run("R7 last pid in range", 1'b1, 16'd255, va_b, tb, 5'd0, '0, '0, '0, 2, 1'b0);
        run("R7 pid out of range", 1'b1, 16'd256, va_b, tb, 5'd0, '0, '0, '0, 1, 1'b0);
        run("R11 request while busy", 1'b0, '0, va_a, '0, '0, 64'h1_0000, 5'd9, 6'd39, 2, 1'b1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule